// File: doc/BRIEF.md
# Access Permission Checker with Per-Master Fault Capture

This block sits after the address translation stage of an I/O memory management unit and rules on every translated access. Each leaf page entry carries a 4-bit authority domain index. The block combines that index with the requesting master's number and looks up a permission matrix. The matrix has 16 domains by 6 masters, and each cell holds a separate read-deny bit and write-deny bit. The block answers allow or deny one cycle after the request. A denied access receives an error response and is never forwarded downstream.

On a deny, the block raises that master's status bit and keeps the faulting virtual address and the offending leaf entry in registers set aside for that master. Two further status bits record invalid first-level and second-level table entries. These are reported by the translation walker on two pulse inputs. An interrupt enable register and a write-one-to-clear register steer a single interrupt line. All registers are reached through a simple word-addressed write port and a combinational read port.

Top module: `acc_perm_guard`

## Requirements
- R1: After reset every status bit, the interrupt enable register and the interrupt line read 0. The permission word at 0x0B0 reads 0x00000AAA, and every other permission word reads 0.
- R2: A request with reqValid high produces rspValid high in the next cycle, and rspValid is low in every other cycle. rspAllow is 1 unless the selected deny bit is set.
- R3: The domain index is reqEntry[7:4]. Domain d lives in the word at byte offset 0x0B0 + (d/2)*4. Its read-deny bit for master m is at position (d&1)*16 + 2m, and its write-deny bit is at the next position up. Writes to these words are read back unchanged.
- R4: A denied access from master m sets status bit m in the status word at 0x108. An allowed access changes no status bit.
- R5: On the first deny from master m, reqAddr is captured at 0x110 + 4m and reqEntry is captured at 0x150 + 4m.
- R6: While status bit m is set, further denies from master m leave both of its capture words unchanged.
- R7: Writing 1s to 0x104 clears the matching status bits and leaves the other bits alone. A deny from master m in the same cycle that clears bit m wins: the bit stays set and the new address and entry are captured.
- R8: The interrupt line is high exactly when some status bit is set whose enable bit in the word at 0x100 is also set. The enable word reads back as written.
- R9: A pulse on walkL1Err sets status bit 16, and a pulse on walkL2Err sets status bit 17.
- R10: With reset permissions, domain 0 allows reads and denies writes for every master. Every other domain allows both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 10 | Register byte offset for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| reqValid | input | 1 | Access request present |
| reqMaster | input | 3 | Requesting master number, 0 to 5 |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| reqAddr | input | 32 | Virtual address of the access |
| reqEntry | input | 32 | Fetched leaf page entry |
| walkL1Err | input | 1 | Invalid first-level entry pulse |
| walkL2Err | input | 1 | Invalid second-level entry pulse |
| rspValid | output | 1 | Decision present |
| rspAllow | output | 1 | 1 to forward the access, 0 for an error response |
| irq | output | 1 | Interrupt request |

## Verification
The decision is due one clock edge after the request. Status bits, capture words and the interrupt change on that same edge, and register writes take effect on the edge that samples them. Reads are combinational, so their value is due as soon as the address settles.

The bench drives every input on the falling edge. The driver queues the expected decision as it issues a request, and a monitor compares the registered response on the following falling edge. Register contents are read back after the write or access task has returned, which places every read at least one full edge after the update it observes.

// File: rtl/acc_perm_guard_pkg.sv
package acc_perm_guard_pkg;
  localparam int NUM_MASTERS = 6;
  localparam int NUM_DOMAINS = 16;
  localparam int REG_AW      = 10;
  localparam int WORD_W      = 32;
  localparam int MID_W       = $clog2(NUM_MASTERS);
  localparam int IDX_W       = $clog2(NUM_DOMAINS);
  localparam int PERM_WORDS  = NUM_DOMAINS / 2;
  localparam int HALF_W      = WORD_W / 2;
  localparam int BIT_W       = $clog2(WORD_W);
  localparam int IDX_LSB     = 4;

  localparam logic [REG_AW-1:0] OFS_PERM  = 10'h0B0;
  localparam logic [REG_AW-1:0] OFS_IEN   = 10'h100;
  localparam logic [REG_AW-1:0] OFS_ICLR  = 10'h104;
  localparam logic [REG_AW-1:0] OFS_ISTAT = 10'h108;
  localparam logic [REG_AW-1:0] OFS_FADDR = 10'h110;
  localparam logic [REG_AW-1:0] OFS_FDATA = 10'h150;
  localparam int WALK1_BIT = 16;
  localparam int WALK2_BIT = 17;

  typedef struct packed {
    logic [PERM_WORDS-1:0]  permWe;
    logic                   enWe;
    logic                   clrWe;
    logic [NUM_MASTERS-1:0] faultSet;
    logic                   walk1Set;
    logic                   walk2Set;
  } strobe_t;

  // Lower-half domain (domain 0) denies writes for every master.
  function automatic logic [WORD_W-1:0] domZeroReset();
    logic [WORD_W-1:0] v;
    v = '0;
    for (int m = 0; m < NUM_MASTERS; m++) v[2*m+1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/acc_perm_guard_ctrl.sv
module acc_perm_guard_ctrl
  import acc_perm_guard_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWe,
  input  logic [REG_AW-1:0]                 regAddr,
  input  logic                              reqValid,
  input  logic [MID_W-1:0]                  reqMaster,
  input  logic                              reqWrite,
  input  logic [WORD_W-1:0]                 reqEntry,
  input  logic                              walkL1Err,
  input  logic                              walkL2Err,
  input  logic [PERM_WORDS-1:0][WORD_W-1:0] permTable,
  output strobe_t                           strobe,
  output logic                              rspValid,
  output logic                              rspAllow
);
  logic [IDX_W-1:0]  domIdx;
  logic [WORD_W-1:0] domWord;
  logic [BIT_W-1:0]  bitPos;
  logic              deny;

  assign domIdx  = reqEntry[IDX_LSB +: IDX_W];
  assign domWord = permTable[domIdx[IDX_W-1:1]];
  assign bitPos  = (domIdx[0] ? BIT_W'(HALF_W) : '0)
                 + BIT_W'({reqMaster, reqWrite});
  assign deny    = domWord[bitPos];

  genvar gi;
  generate
    for (gi = 0; gi < PERM_WORDS; gi++) begin : g_permDec
      assign strobe.permWe[gi] = regWe && (regAddr == REG_AW'(OFS_PERM + 4*gi));
    end
    for (gi = 0; gi < NUM_MASTERS; gi++) begin : g_faultDec
      assign strobe.faultSet[gi] = reqValid && deny && (reqMaster == MID_W'(gi));
    end
  endgenerate

  assign strobe.enWe     = regWe && (regAddr == OFS_IEN);
  assign strobe.clrWe    = regWe && (regAddr == OFS_ICLR);
  assign strobe.walk1Set = walkL1Err;
  assign strobe.walk2Set = walkL2Err;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspAllow <= reqValid && !deny;
    end
  end
endmodule

// File: rtl/acc_perm_guard_dp.sv
module acc_perm_guard_dp
  import acc_perm_guard_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strobe,
  input  logic [REG_AW-1:0]                  regAddr,
  input  logic [WORD_W-1:0]                  regWdata,
  input  logic [WORD_W-1:0]                  reqAddr,
  input  logic [WORD_W-1:0]                  reqEntry,
  output logic [WORD_W-1:0]                  regRdata,
  output logic                               irq,
  output logic [WORD_W-1:0]                  statusVec,
  output logic [PERM_WORDS-1:0][WORD_W-1:0]  permTable,
  output logic [NUM_MASTERS-1:0][WORD_W-1:0] capAddr,
  output logic [NUM_MASTERS-1:0][WORD_W-1:0] capData
);
  logic [WORD_W-1:0] intEnable;
  logic [WORD_W-1:0] clrMask;

  assign clrMask = strobe.clrWe ? regWdata : '0;

  genvar gi;
  generate
    for (gi = 0; gi < PERM_WORDS; gi++) begin : g_perm
      localparam logic [WORD_W-1:0] RST_VAL = (gi == 0) ? domZeroReset() : '0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) permTable[gi] <= RST_VAL;
        else if (strobe.permWe[gi]) permTable[gi] <= regWdata;
      end
    end
    for (gi = 0; gi < NUM_MASTERS; gi++) begin : g_master
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusVec[gi] <= 1'b0;
          capAddr[gi]   <= '0;
          capData[gi]   <= '0;
        end else begin
          statusVec[gi] <= strobe.faultSet[gi] || (statusVec[gi] && !clrMask[gi]);
          if (strobe.faultSet[gi] && (!statusVec[gi] || clrMask[gi])) begin
            capAddr[gi] <= reqAddr;
            capData[gi] <= reqEntry;
          end
        end
      end
    end
    for (gi = NUM_MASTERS; gi < WORD_W; gi++) begin : g_stat
      if (gi == WALK1_BIT || gi == WALK2_BIT) begin : g_walk
        logic setHere;
        assign setHere = (gi == WALK1_BIT) ? strobe.walk1Set : strobe.walk2Set;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) statusVec[gi] <= 1'b0;
          else statusVec[gi] <= setHere || (statusVec[gi] && !clrMask[gi]);
        end
      end else begin : g_unused
        assign statusVec[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intEnable <= '0;
    else if (strobe.enWe) intEnable <= regWdata;
  end

  assign irq = |(statusVec & intEnable);

  always_comb begin
    regRdata = '0;
    if (regAddr == OFS_IEN)   regRdata = intEnable;
    if (regAddr == OFS_ISTAT) regRdata = statusVec;
    for (int i = 0; i < PERM_WORDS; i++)
      if (regAddr == REG_AW'(OFS_PERM + 4*i)) regRdata = permTable[i];
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (regAddr == REG_AW'(OFS_FADDR + 4*m)) regRdata = capAddr[m];
      if (regAddr == REG_AW'(OFS_FDATA + 4*m)) regRdata = capData[m];
    end
  end
endmodule

// File: rtl/acc_perm_guard.sv
module acc_perm_guard
  import acc_perm_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [9:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              reqValid,
  input  logic [2:0]        reqMaster,
  input  logic              reqWrite,
  input  logic [31:0]       reqAddr,
  input  logic [31:0]       reqEntry,
  input  logic              walkL1Err,
  input  logic              walkL2Err,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              irq
);
  strobe_t                            ctrlStrobe;
  logic [WORD_W-1:0]                  statusVec;
  logic [PERM_WORDS-1:0][WORD_W-1:0]  permTable;
  logic [NUM_MASTERS-1:0][WORD_W-1:0] capAddr;
  logic [NUM_MASTERS-1:0][WORD_W-1:0] capData;

  acc_perm_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .reqValid(reqValid), .reqMaster(reqMaster), .reqWrite(reqWrite),
    .reqEntry(reqEntry), .walkL1Err(walkL1Err), .walkL2Err(walkL2Err),
    .permTable(permTable), .strobe(ctrlStrobe),
    .rspValid(rspValid), .rspAllow(rspAllow)
  );

  acc_perm_guard_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .regAddr(regAddr),
    .regWdata(regWdata), .reqAddr(reqAddr), .reqEntry(reqEntry),
    .regRdata(regRdata), .irq(irq), .statusVec(statusVec),
    .permTable(permTable), .capAddr(capAddr), .capData(capData)
  );
endmodule

// File: rtl/acc_perm_guard_chk.sv
module acc_perm_guard_chk
  import acc_perm_guard_pkg::*;
(
  input logic                               clk,
  input logic                               rstN,
  input logic                               reqValid,
  input logic [MID_W-1:0]                   reqMaster,
  input logic                               rspValid,
  input logic                               rspAllow,
  input logic                               irq,
  input logic [WORD_W-1:0]                  statusVec,
  input logic                               clrWe,
  input logic [WORD_W-1:0]                  regWdata,
  input logic [NUM_MASTERS-1:0]             faultSet,
  input logic [NUM_MASTERS-1:0][WORD_W-1:0] capAddr
);
  logic [MID_W-1:0] lastMaster;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastMaster <= '0;
    else lastMaster <= reqMaster;
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R4
  deny_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAllow) |-> statusVec[lastMaster]);
  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec == '0) |-> !irq);

  genvar gm;
  generate
    for (gm = 0; gm < NUM_MASTERS; gm++) begin : g_m
      // R6
      capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (statusVec[gm] && !(clrWe && regWdata[gm])) |=> $stable(capAddr[gm]));
      // R7
      clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
        (clrWe && regWdata[gm] && !faultSet[gm]) |=> !statusVec[gm]);
    end
  endgenerate
endmodule

bind acc_perm_guard acc_perm_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMaster(reqMaster),
  .rspValid(rspValid), .rspAllow(rspAllow), .irq(irq), .statusVec(statusVec),
  .clrWe(ctrlStrobe.clrWe), .regWdata(regWdata),
  .faultSet(ctrlStrobe.faultSet), .capAddr(capAddr)
);

// File: tb/acc_perm_guard_bench.sv
module acc_perm_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMaster = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqEntry = '0;
  logic        walkL1Err = 1'b0;
  logic        walkL2Err = 1'b0;
  logic        rspValid, rspAllow, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit    expQ[$];
  string tagQ[$];
  logic [31:0] benchPerm [8];

  acc_perm_guard u_acc_perm_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    if (a >= 10'h0B0 && a <= 10'h0CC) benchPerm[(a - 10'h0B0) >> 2] = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regCheck(string tag, logic [9:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    checkEq(tag, regRdata, exp);
  endtask

  function automatic logic [31:0] mkEntry(logic [31:0] page, int dom);
    return {page[31:12], 4'h0, 4'(dom), 4'b0010};
  endfunction

  function automatic bit expAllow(int m, bit w, int dom);
    return !benchPerm[dom >> 1][(dom & 1) * 16 + 2 * m + w];
  endfunction

  task automatic startAccess(string tag, int m, bit w, logic [31:0] a, int dom);
    reqValid = 1'b1; reqMaster = 3'(m); reqWrite = w;
    reqAddr = a; reqEntry = mkEntry(a, dom);
    expQ.push_back(expAllow(m, w, dom));
    tagQ.push_back(tag);
  endtask

  task automatic doAccess(string tag, int m, bit w, logic [31:0] a, int dom);
    @(negedge clk);
    startAccess(tag, m, w, a, dom);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares each registered decision one edge after its request.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        checkEq("R2 unexpected response", 32'(rspValid), 32'd0);
      end else begin
        string t;
        bit e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkEq(t, 32'(rspAllow), 32'(e));
      end
    end
  end

  task automatic finishTest();
    checkEq("R2 response queue drained", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    benchPerm[0] = 32'h00000AAA;
    for (int i = 1; i < 8; i++) benchPerm[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regCheck("R1 status", 10'h108, 32'h0);
    regCheck("R1 enable", 10'h100, 32'h0);
    regCheck("R1 domain 0/1 word", 10'h0B0, 32'h00000AAA);
    regCheck("R1 domain 14/15 word", 10'h0CC, 32'h0);
    checkEq("R1 irq", 32'(irq), 32'd0);

    // R10 domain 0 read-only, other domains open
    doAccess("R10 dom0 read m2", 2, 1'b0, 32'h1000_0123, 0);
    doAccess("R10 dom7 write m5", 5, 1'b1, 32'h2000_0000, 7);
    regCheck("R4 allowed leaves status", 10'h108, 32'h0);
    doAccess("R10 dom0 write m2 denied", 2, 1'b1, 32'h1234_5678, 0);
    regCheck("R4 status bit 2", 10'h108, 32'h4);
    regCheck("R5 fault address m2", 10'h118, 32'h1234_5678);
    regCheck("R5 fault entry m2", 10'h158, mkEntry(32'h1234_5678, 0));

    // R6 second fault does not overwrite
    doAccess("R6 repeat deny m2", 2, 1'b1, 32'h9999_0000, 0);
    regCheck("R6 address held", 10'h118, 32'h1234_5678);
    regCheck("R6 entry held", 10'h158, mkEntry(32'h1234_5678, 0));

    // R8 interrupt gating
    @(negedge clk);
    checkEq("R8 irq masked", 32'(irq), 32'd0);
    regWrite(10'h100, 32'h0003_0004);
    regCheck("R8 enable readback", 10'h100, 32'h0003_0004);
    checkEq("R8 irq enabled", 32'(irq), 32'd1);

    // R7 write-one-to-clear
    regWrite(10'h104, 32'h0000_0001);
    regCheck("R7 unrelated bit kept", 10'h108, 32'h4);
    regWrite(10'h104, 32'h0000_0004);
    regCheck("R7 bit cleared", 10'h108, 32'h0);
    checkEq("R8 irq drops", 32'(irq), 32'd0);

    // R3 packing: domain 5 in upper half of word 0x0B8, master 4 read deny
    regWrite(10'h0B8, 32'h1 << 24);
    regCheck("R3 readback", 10'h0B8, 32'h0100_0000);
    doAccess("R3 dom5 read m4 denied", 4, 1'b0, 32'hAAAA_1000, 5);
    doAccess("R3 dom5 write m4 allowed", 4, 1'b1, 32'hAAAA_2000, 5);
    doAccess("R3 dom5 read m3 allowed", 3, 1'b0, 32'hAAAA_3000, 5);
    doAccess("R3 dom4 read m4 allowed", 4, 1'b0, 32'hAAAA_4000, 4);
    regCheck("R4 status bit 4", 10'h108, 32'h10);
    regCheck("R5 fault address m4", 10'h120, 32'hAAAA_1000);
    regCheck("R5 fault entry m4", 10'h160, mkEntry(32'hAAAA_1000, 5));

    // R7 clear and new fault in the same cycle: fault wins, new capture
    @(negedge clk);
    regWe = 1'b1; regAddr = 10'h104; regWdata = 32'h10;
    startAccess("R7 deny during clear m4", 4, 1'b0, 32'hBBBB_0000, 5);
    @(negedge clk);
    regWe = 1'b0; reqValid = 1'b0;
    regCheck("R7 status kept by fault", 10'h108, 32'h10);
    regCheck("R7 recapture address", 10'h120, 32'hBBBB_0000);

    // R9 walker error bits
    regWrite(10'h104, 32'h10);
    @(negedge clk);
    walkL1Err = 1'b1;
    @(negedge clk);
    walkL1Err = 1'b0;
    regCheck("R9 first-level bit", 10'h108, 32'h0001_0000);
    checkEq("R8 irq from walk bit", 32'(irq), 32'd1);
    @(negedge clk);
    walkL2Err = 1'b1;
    @(negedge clk);
    walkL2Err = 1'b0;
    regCheck("R9 both walk bits", 10'h108, 32'h0003_0000);
    regWrite(10'h104, 32'h0003_0000);
    regCheck("R7 walk bits cleared", 10'h108, 32'h0);

    repeat (2) @(negedge clk);
    finishTest();
  end
endmodule